// File: doc/BRIEF.md
# Byte-Wide Link Port Transmitter

This block moves one 128-bit quad-word at a time across an 8-bit point-to-point link. A word is taken from a valid/ready input and held in an internal buffer. The block then drives the direction pin and, with its own clock line held high, waits for the far end to answer on the return clock line. The far end answers with a low connectivity pulse. When the return line then stays high for half a link period, the block sends the word as sixteen bytes, one byte per edge of the transmit link clock. If verification is on, an XOR check byte and a zero dummy byte follow the data bytes.

The block runs from a clock at twice the core rate (`clk2x`). A link ratio R of 2, 3, 4 or 8 therefore gives a link period of 2R ticks with two phases of exactly R ticks each, so every ratio meets its duty-cycle window. The ratio and the verification switch are captured only when a word is accepted. The data pins are tri-stated, through `ldat_oe`, whenever no word is on the wire.

Top module: `lnk8_tx`

## Requirements
- R1: `ratio_sel` codes 0, 1, 2 and 3 select R = 2, 3, 4 and 8. Every link clock phase during a transfer lasts exactly R ticks of `clk2x`.
- R2: `ratio_sel`, `vfy_en` and `in_data` are used only in the tick where a word is accepted. Changing them later has no effect on the word being sent.
- R3: `in_ready` is high only while idle. A word is accepted on a tick where `in_valid` and `in_ready` are both high. On the next tick `in_ready` is low.
- R4: During transfer phase h (h = 0, 1, ...), `ldat_o` carries byte h, which is `in_data[8h+7:8h]`. `lclk_out` is low in even phases and high in odd phases, so the first edge is falling and every byte starts on an edge.
- R5: `ldir` goes high on the tick after acceptance. It stays high through the transfer and for R further ticks after the last byte, and is low when idle.
- R6: After acceptance, `lclk_out` stays high and `ldat_oe` stays low until `lclk_in` has been sampled low and then sampled high on R consecutive ticks. A return to low before the R-th high tick restarts the wait. A line that stays low keeps the block waiting.
- R7: `ldat_oe` rises one tick before byte 0, with `ldat_o` = 0 on that tick. It falls right after the last byte. `ldat_o` is 0 whenever `ldat_oe` is low.
- R8: With `vfy_en` captured high, phase 16 carries the XOR of the sixteen data bytes and phase 17 carries 0x00, giving 18 phases. With it low, the transfer ends after phase 15.
- R9: After reset, `in_ready`=1, `ldir`=0, `ldat_oe`=0, `lclk_out`=1 and `ldat_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the core rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 128 | Quad-word to send, byte 0 in bits 7:0 |
| in_valid | input | 1 | Quad-word present |
| in_ready | output | 1 | Port idle, word will be taken |
| ratio_sel | input | 2 | Link ratio code (0:2, 1:3, 2:4, 3:8) |
| vfy_en | input | 1 | Append check byte and dummy byte |
| lclk_out | output | 1 | Transmit link clock |
| lclk_in | input | 1 | Return clock line carrying the handshake |
| ldat_o | output | 8 | Link data byte |
| ldat_oe | output | 1 | Data pin output enable |
| ldir | output | 1 | Direction, high while transmitting |

## Verification
The bench tries both forms of not-acknowledge. In one, the return line goes high for R-1 ticks and then drops again. In the other, it stays low for many ticks. A design that counted high ticks without restarting would start sending into a refusing receiver in the first case. The bench also changes the ratio, the verification switch and the input word right after acceptance. A design that read live inputs would then show phases of the wrong length or the wrong bytes. Each ratio is run with verification on and off, including the R=2 edge case. This catches check bytes built from the wrong bytes, missing dummy bytes and an enable that is held one phase too long.

// File: rtl/lnk8_tx.sv
module lnk8_tx #(
  parameter int BYTES = 16
) (
  input  logic                 clk2x,
  input  logic                 rst_n,
  input  logic [BYTES*8-1:0]   in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           ratio_sel,
  input  logic                 vfy_en,
  output logic                 lclk_out,
  input  logic                 lclk_in,
  output logic [7:0]           ldat_o,
  output logic                 ldat_oe,
  output logic                 ldir
);
  localparam int DW = BYTES * 8;
  localparam int IW = $clog2(BYTES);
  localparam int HW = $clog2(BYTES + 2);

  typedef enum logic [2:0] {S_IDLE, S_ACK, S_OE, S_XFER, S_HOLD} st_t;

  st_t            st_q;
  logic [DW-1:0]  buf_q;
  logic [3:0]     rat_q;
  logic [3:0]     cnt_q;
  logic [HW-1:0]  ph_q;
  logic           seen_q;
  logic           vfy_q;
  logic [7:0]     chk_byte;
  logic [7:0]     cur_byte;

  wire            end_tick = (cnt_q == rat_q - 4'd1);
  wire [HW-1:0]   last_ph  = vfy_q ? HW'(BYTES + 1) : HW'(BYTES - 1);

  function automatic logic [3:0] dec_ratio(input logic [1:0] s);
    case (s)
      2'd0:    return 4'd2;
      2'd1:    return 4'd3;
      2'd2:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  always_comb begin
    chk_byte = 8'h00;
    for (int i = 0; i < BYTES; i++) chk_byte = chk_byte ^ buf_q[i*8 +: 8];
  end

  always_comb begin
    if (ph_q < HW'(BYTES))      cur_byte = buf_q[{ph_q[IW-1:0], 3'b000} +: 8];
    else if (ph_q == HW'(BYTES)) cur_byte = chk_byte;
    else                         cur_byte = 8'h00;
  end

  assign in_ready = (st_q == S_IDLE);
  assign ldir     = (st_q != S_IDLE);
  assign ldat_oe  = (st_q == S_OE) || (st_q == S_XFER);
  assign lclk_out = (st_q == S_XFER) ? ph_q[0] : 1'b1;
  assign ldat_o   = (st_q == S_XFER) ? cur_byte : 8'h00;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      buf_q  <= '0;
      rat_q  <= 4'd2;
      cnt_q  <= '0;
      ph_q   <= '0;
      seen_q <= 1'b0;
      vfy_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (in_valid) begin
          buf_q  <= in_data;
          rat_q  <= dec_ratio(ratio_sel);
          vfy_q  <= vfy_en;
          seen_q <= 1'b0;
          cnt_q  <= '0;
          st_q   <= S_ACK;
        end
        S_ACK: begin
          if (!lclk_in) begin
            seen_q <= 1'b1;
            cnt_q  <= '0;
          end else if (seen_q) begin
            if (end_tick) begin
              cnt_q <= '0;
              ph_q  <= '0;
              st_q  <= S_OE;
            end else begin
              cnt_q <= cnt_q + 4'd1;
            end
          end
        end
        S_OE: st_q <= S_XFER;
        S_XFER: begin
          if (end_tick) begin
            cnt_q <= '0;
            if (ph_q == last_ph) st_q <= S_HOLD;
            else                 ph_q <= ph_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 4'd1;
          end
        end
        S_HOLD: begin
          if (end_tick) begin
            cnt_q <= '0;
            st_q  <= S_IDLE;
          end else begin
            cnt_q <= cnt_q + 4'd1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lnk8_tx_chk.sv
module lnk8_tx_chk (
  input logic       clk2x,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       lclk_out,
  input logic [7:0] ldat_o,
  input logic       ldat_oe,
  input logic       ldir
);
  p_dat_quiet_r7: assert property (@(posedge clk2x) disable iff (!rst_n)
    !ldat_oe |-> ldat_o == 8'h00);

  p_oe_rise_r7: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(ldat_oe) |-> (ldat_o == 8'h00) && lclk_out);

  p_ready_idle_r3: assert property (@(posedge clk2x) disable iff (!rst_n)
    in_ready |-> !ldir && !ldat_oe);

  p_accept_r3: assert property (@(posedge clk2x) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready && ldir);

  p_oe_in_dir_r5: assert property (@(posedge clk2x) disable iff (!rst_n)
    ldat_oe |-> ldir);

  p_dir_first_r5: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(ldat_oe) |-> $past(ldir));

  p_clk_parked_r6: assert property (@(posedge clk2x) disable iff (!rst_n)
    !ldat_oe |-> lclk_out);
endmodule

bind lnk8_tx lnk8_tx_chk u_chk (
  .clk2x(clk2x), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .lclk_out(lclk_out), .ldat_o(ldat_o), .ldat_oe(ldat_oe), .ldir(ldir)
);

// File: tb/sim_lnk8_tx.sv
`timescale 1ns/1ps
module sim_lnk8_tx;
  logic         clk2x = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] in_data = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   ratio_sel = 2'd0;
  logic         vfy_en = 1'b0;
  logic         lclk_out;
  logic         lclk_in = 1'b1;
  logic [7:0]   ldat_o;
  logic         ldat_oe;
  logic         ldir;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #10 clk2x = ~clk2x;

  lnk8_tx u0 (
    .clk2x(clk2x), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .ratio_sel(ratio_sel), .vfy_en(vfy_en),
    .lclk_out(lclk_out), .lclk_in(lclk_in), .ldat_o(ldat_o),
    .ldat_oe(ldat_oe), .ldir(ldir)
  );

  function automatic int rat_of(input logic [1:0] s);
    case (s)
      2'd0: return 2;
      2'd1: return 3;
      2'd2: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic logic [7:0] exp_byte(input logic [127:0] d, input int h);
    logic [7:0] x = 8'h00;
    if (h < 16) return d[h*8 +: 8];
    if (h == 16) begin
      for (int i = 0; i < 16; i++) x = x ^ d[i*8 +: 8];
      return x;
    end
    return 8'h00;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_word(input logic [127:0] d, input logic [1:0] rs,
                           input logic vf, input int mode);
    int r = rat_of(rs);
    int n = vf ? 18 : 16;
    @(negedge clk2x);
    chk("R3 ready before accept", in_ready, 1);
    in_data = d; ratio_sel = rs; vfy_en = vf; in_valid = 1'b1;
    @(negedge clk2x);
    in_valid = 1'b0;
    in_data = {$urandom, $urandom, $urandom, $urandom};
    ratio_sel = rs + 2'd1;
    vfy_en = ~vf;
    chk("R3 ready drops", in_ready, 0);
    chk("R5 dir up", ldir, 1);
    chk("R6 oe low waiting", ldat_oe, 0);
    chk("R6 clk parked high", lclk_out, 1);
    if (mode == 1) begin
      lclk_in = 1'b0;
      @(negedge clk2x);
      lclk_in = 1'b1;
      for (int k = 0; k < r - 1; k++) begin
        @(negedge clk2x);
        chk("R6 short high no start", ldat_oe, 0);
      end
      lclk_in = 1'b0;
      @(negedge clk2x);
      chk("R6 relow is nack", ldat_oe, 0);
    end else if (mode == 2) begin
      lclk_in = 1'b0;
      for (int k = 0; k < 3 * r; k++) begin
        @(negedge clk2x);
        chk("R6 stay low waits", ldat_oe, 0);
        chk("R6 clk high in nack", lclk_out, 1);
      end
    end
    lclk_in = 1'b0;
    @(negedge clk2x);
    lclk_in = 1'b1;
    for (int k = 1; k <= r; k++) begin
      @(negedge clk2x);
      if (k < r) chk("R6 ack not yet", ldat_oe, 0);
      else begin
        chk("R7 oe one tick early", ldat_oe, 1);
        chk("R7 data zero on oe tick", ldat_o, 0);
        chk("R6 clk high on oe tick", lclk_out, 1);
      end
    end
    for (int h = 0; h < n; h++) begin
      for (int c = 0; c < r; c++) begin
        @(negedge clk2x);
        chk(h < 16 ? "R4 data byte" : "R8 check/dummy byte", ldat_o, exp_byte(d, h));
        chk("R1 link clock phase", lclk_out, h % 2);
        chk("R7 oe during transfer", ldat_oe, 1);
        chk("R2 latched settings", ldir, 1);
      end
    end
    for (int k = 0; k < r; k++) begin
      @(negedge clk2x);
      chk("R7 oe off after last", ldat_oe, 0);
      chk("R5 dir hold", ldir, 1);
      chk("R7 data quiet", ldat_o, 0);
    end
    @(negedge clk2x);
    chk("R5 dir low idle", ldir, 0);
    chk("R3 ready back", in_ready, 1);
  endtask

  initial begin
    #(150000 * 20);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #35;
    chk("R9 ready", in_ready, 1);
    chk("R9 dir", ldir, 0);
    chk("R9 oe", ldat_oe, 0);
    chk("R9 clk", lclk_out, 1);
    chk("R9 data", ldat_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk2x);
    chk("R3 idle without valid", ldir, 0);
    send_word(128'h0f0e0d0c0b0a09080706050403020100, 2'd0, 1'b1, 0);
    send_word('1, 2'd1, 1'b0, 1);
    send_word('0, 2'd2, 1'b1, 2);
    send_word(128'h0123456789abcdeffedcba9876543210, 2'd3, 1'b1, 1);
    send_word(128'h80402010080402010102040810204080, 2'd0, 1'b0, 2);
    for (int i = 0; i < 20; i++)
      send_word({$urandom, $urandom, $urandom, $urandom}, 2'($urandom % 4),
                1'($urandom % 2), int'($urandom % 3));
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule